// File: doc/BRIEF.md
# Software Write-Protect Sequence Detector

This block sits between the byte-load front end of a page-programmed nonvolatile memory and its page write sequencer. It examines each address/data load and keeps a software protection mode. While protection is on, a write is passed on only if a three-load unlock code came before it. A six-load code turns protection off. The loads that make up either code are flagged so that the sequencer never stores them as data.

A successful unlock opens a page window. Every load in that window is allowed, and the window stays open until the sequencer reports that its program cycle has started. The unlock code alone does not change the protection state. The first data load inside the window arms protection, and that load is also programmed. The protection state is held in a register that clears on reset.

For each load, the verdict appears as a one-cycle pulse on the clock edge after the load. A write-allow pulse tells the sequencer to accept the byte. A command pulse tells it to drop the byte because it was part of a code. If neither pulses, the byte was blocked.

Top module: `swp_guard`

## Requirements
- R1: After a synchronous reset, `prot_on`, `wr_allow` and `cmd_sup` are all 0.
- R2: `wr_allow` and `cmd_sup` can pulse only in the cycle after a cycle with `ld_vld` high, and they are never both 1.
- R3: The unlock code is the load 5555h/AAh, then 2AAAh/55h, then 5555h/A0h. Each of these loads gives `cmd_sup`=1 and `wr_allow`=0. The code alone leaves `prot_on` unchanged.
- R4: The first load after a completed unlock gives `wr_allow`=1 and sets `prot_on` to 1 in the same cycle.
- R5: After an unlock, every load gives `wr_allow`=1 until `prog_start` is sampled high. A load in the same cycle as `prog_start` is still inside the window.
- R6: While `prot_on`=1 and no window is open, a load that is not a code step gives `wr_allow`=0 and `cmd_sup`=0.
- R7: While `prot_on`=0, a load that is not a code step gives `wr_allow`=1.
- R8: The disable code is six loads: 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, 5555h/20h. Each of these loads gives `cmd_sup`=1, and `prot_on` drops to 0 together with the pulse for the sixth load.
- R9: A load that breaks a partly matched code returns the detector to idle. That load is judged as an ordinary write under the present protection state.
- R10: A breaking load that is itself 5555h/AAh is treated as the first step of a new code (`cmd_sup`=1). The next load is then matched against step two.
- R11: The disable code given while protection is off is fully suppressed, and `prot_on` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_vld | input | 1 | Byte-load strobe, one cycle per load |
| ld_addr | input | ADDR_W (15) | Address of the load |
| ld_data | input | DATA_W (8) | Data byte of the load |
| prog_start | input | 1 | Sequencer has begun its program cycle; closes the page window |
| prot_on | output | 1 | Software protection currently enabled |
| wr_allow | output | 1 | Pulse: the previous load may be written |
| cmd_sup | output | 1 | Pulse: the previous load was a code byte and must not be stored |

## Verification
The checker's rules for the output pulses assume that a load lasts exactly one cycle per `ld_vld` pulse, so that each pulse refers to a single load. They also assume that the address and data are stable during that cycle. The bench drives each load for one clock between falling edges and lowers the strobe before the next load. It never leaves `ld_addr` or `ld_data` changing while the strobe is high. In the random phase, `prog_start` is raised on its own and together with loads, which covers the case where a window closes and a load arrives in the same cycle.

// File: rtl/swp_pkg.sv
package swp_pkg;
  // indices into the code-pattern table
  localparam int PAT_OPEN   = 0;  // first step of both codes
  localparam int PAT_SECOND = 1;
  localparam int PAT_UNLOCK = 2;
  localparam int PAT_ERASE  = 3;
  localparam int PAT_FINAL  = 4;
  localparam int NPAT       = 5;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_K1   = 3'd1,  // open step seen
    ST_K2   = 3'd2,  // second step seen
    ST_E3   = 3'd3,  // erase marker seen
    ST_E4   = 3'd4,  // repeated open seen
    ST_E5   = 3'd5   // repeated second seen
  } swp_step_e;
endpackage

// File: rtl/swp_match.sv
module swp_match #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int NPAT   = 5,
  parameter logic [NPAT*ADDR_W-1:0] PAT_ADDR = '0,
  parameter logic [NPAT*DATA_W-1:0] PAT_DATA = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [NPAT-1:0]   hit
);
  for (genvar g = 0; g < NPAT; g++) begin : g_pat
    assign hit[g] = (addr == PAT_ADDR[g*ADDR_W +: ADDR_W]) &&
                    (data == PAT_DATA[g*DATA_W +: DATA_W]);
  end
endmodule

// File: rtl/swp_seq.sv
module swp_seq
  import swp_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_vld,
  input  logic [NPAT-1:0] hit,
  input  logic            prog_start,
  output logic            allow_d,
  output logic            sup_d,
  output logic            prot_q
);
  swp_step_e step_q, step_n;
  logic      win_q, win_n, prot_n, adv;

  always_comb begin
    step_n  = step_q;
    win_n   = win_q;
    prot_n  = prot_q;
    allow_d = 1'b0;
    sup_d   = 1'b0;
    adv     = 1'b0;
    if (ld_vld) begin
      if (win_q) begin
        allow_d = 1'b1;
        prot_n  = 1'b1;
      end else begin
        case (step_q)
          ST_IDLE: if (hit[PAT_OPEN])   begin step_n = ST_K1; adv = 1'b1; end
          ST_K1:   if (hit[PAT_SECOND]) begin step_n = ST_K2; adv = 1'b1; end
          ST_K2: begin
            if (hit[PAT_UNLOCK]) begin
              step_n = ST_IDLE;
              win_n  = 1'b1;
              adv    = 1'b1;
            end else if (hit[PAT_ERASE]) begin
              step_n = ST_E3;
              adv    = 1'b1;
            end
          end
          ST_E3:   if (hit[PAT_OPEN])   begin step_n = ST_E4; adv = 1'b1; end
          ST_E4:   if (hit[PAT_SECOND]) begin step_n = ST_E5; adv = 1'b1; end
          ST_E5: begin
            if (hit[PAT_FINAL]) begin
              step_n = ST_IDLE;
              prot_n = 1'b0;
              adv    = 1'b1;
            end
          end
          default: step_n = ST_IDLE;
        endcase
        if (adv) begin
          sup_d = 1'b1;
        end else if (hit[PAT_OPEN]) begin
          step_n = ST_K1;
          sup_d  = 1'b1;
        end else begin
          step_n  = ST_IDLE;
          allow_d = ~prot_q;
        end
      end
    end
    if (prog_start) win_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= ST_IDLE;
      win_q  <= 1'b0;
      prot_q <= 1'b0;
    end else begin
      step_q <= step_n;
      win_q  <= win_n;
      prot_q <= prot_n;
    end
  end
endmodule

// File: rtl/swp_out.sv
module swp_out (
  input  logic clk,
  input  logic rst,
  input  logic ld_vld,
  input  logic allow_d,
  input  logic sup_d,
  output logic wr_allow,
  output logic cmd_sup
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_allow <= 1'b0;
      cmd_sup  <= 1'b0;
    end else begin
      wr_allow <= ld_vld & allow_d;
      cmd_sup  <= ld_vld & sup_d;
    end
  end
endmodule

// File: rtl/swp_guard.sv
module swp_guard
  import swp_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A  = 'h5555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B  = 'h2AAA,
  parameter logic [DATA_W-1:0] OPEN_DATA   = 'hAA,
  parameter logic [DATA_W-1:0] SECOND_DATA = 'h55,
  parameter logic [DATA_W-1:0] UNLOCK_DATA = 'hA0,
  parameter logic [DATA_W-1:0] ERASE_DATA  = 'h80,
  parameter logic [DATA_W-1:0] FINAL_DATA  = 'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_vld,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              prog_start,
  output logic              prot_on,
  output logic              wr_allow,
  output logic              cmd_sup
);
  localparam logic [NPAT*ADDR_W-1:0] PAT_ADDR =
    {KEY_ADDR_A, KEY_ADDR_A, KEY_ADDR_A, KEY_ADDR_B, KEY_ADDR_A};
  localparam logic [NPAT*DATA_W-1:0] PAT_DATA =
    {FINAL_DATA, ERASE_DATA, UNLOCK_DATA, SECOND_DATA, OPEN_DATA};

  logic [NPAT-1:0] hit;
  logic            allow_d, sup_d;

  swp_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NPAT(NPAT),
    .PAT_ADDR(PAT_ADDR), .PAT_DATA(PAT_DATA)
  ) u_match (
    .addr(ld_addr), .data(ld_data), .hit(hit)
  );

  swp_seq u_seq (
    .clk(clk), .rst(rst), .ld_vld(ld_vld), .hit(hit),
    .prog_start(prog_start), .allow_d(allow_d), .sup_d(sup_d),
    .prot_q(prot_on)
  );

  swp_out u_out (
    .clk(clk), .rst(rst), .ld_vld(ld_vld), .allow_d(allow_d),
    .sup_d(sup_d), .wr_allow(wr_allow), .cmd_sup(cmd_sup)
  );
endmodule

// File: rtl/swp_guard_chk.sv
module swp_guard_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 'h5555,
  parameter logic [DATA_W-1:0] FINAL_DATA = 'h20
) (
  input logic              clk,
  input logic              rst,
  input logic              ld_vld,
  input logic [ADDR_W-1:0] ld_addr,
  input logic [DATA_W-1:0] ld_data,
  input logic              prot_on,
  input logic              wr_allow,
  input logic              cmd_sup
);
  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!prot_on && !wr_allow && !cmd_sup));

  // R2
  p_verdict_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr_allow && cmd_sup));

  // R2
  p_no_load_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !ld_vld |=> (!wr_allow && !cmd_sup));

  // R4
  p_arm_with_write_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(prot_on) |-> wr_allow);

  // R8
  p_disarm_by_final_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(prot_on) |-> (cmd_sup && $past(ld_addr) == KEY_ADDR_A &&
                        $past(ld_data) == FINAL_DATA));
endmodule

bind swp_guard swp_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .KEY_ADDR_A(KEY_ADDR_A), .FINAL_DATA(FINAL_DATA)
) u_chk (
  .clk(clk), .rst(rst), .ld_vld(ld_vld), .ld_addr(ld_addr),
  .ld_data(ld_data), .prot_on(prot_on), .wr_allow(wr_allow),
  .cmd_sup(cmd_sup)
);

// File: tb/test_swp_guard.sv
`timescale 1ns/1ps
module test_swp_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_vld = 1'b0;
  logic [14:0] ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic        prog_start = 1'b0;
  logic        prot_on, wr_allow, cmd_sup;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;  // 250 MHz

  swp_guard i_swp_guard (
    .clk(clk), .rst(rst), .ld_vld(ld_vld), .ld_addr(ld_addr),
    .ld_data(ld_data), .prog_start(prog_start), .prot_on(prot_on),
    .wr_allow(wr_allow), .cmd_sup(cmd_sup)
  );

  // ---------------- behavioural reference model ----------------
  int m_step;
  int m_nxt;
  bit m_win, m_prot, e_allow, e_sup;

  function automatic bit is_ld(int a, int d);
    return (int'(ld_addr) == a) && (int'(ld_data) == d);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_step = 0; m_win = 0; m_prot = 0; e_allow = 0; e_sup = 0;
    end else begin
      e_allow = 0; e_sup = 0;
      if (ld_vld) begin
        if (m_win) begin
          e_allow = 1; m_prot = 1;
        end else begin
          m_nxt = -1;
          if (m_step == 0 && is_ld('h5555, 'hAA)) m_nxt = 1;
          if (m_step == 1 && is_ld('h2AAA, 'h55)) m_nxt = 2;
          if (m_step == 2 && is_ld('h5555, 'hA0)) m_nxt = 10;
          if (m_step == 2 && is_ld('h5555, 'h80)) m_nxt = 3;
          if (m_step == 3 && is_ld('h5555, 'hAA)) m_nxt = 4;
          if (m_step == 4 && is_ld('h2AAA, 'h55)) m_nxt = 5;
          if (m_step == 5 && is_ld('h5555, 'h20)) m_nxt = 11;
          if (m_nxt == 10) begin m_step = 0; m_win = 1; e_sup = 1; end
          else if (m_nxt == 11) begin m_step = 0; m_prot = 0; e_sup = 1; end
          else if (m_nxt >= 0) begin m_step = m_nxt; e_sup = 1; end
          else if (is_ld('h5555, 'hAA)) begin m_step = 1; e_sup = 1; end
          else begin m_step = 0; e_allow = !m_prot; end
        end
      end
      if (prog_start) m_win = 0;
    end
  end

  task automatic chk(bit act, bit exp, string what, string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(prot_on,  m_prot,  "model prot_on",  cur_req);
      chk(wr_allow, e_allow, "model wr_allow", cur_req);
      chk(cmd_sup,  e_sup,   "model cmd_sup",  cur_req);
    end
  end

  // one load; returns at the falling edge after the verdict is registered
  task automatic load(int a, int d, bit ps = 0);
    @(negedge clk);
    ld_vld = 1; ld_addr = 15'(a); ld_data = 8'(d); prog_start = ps;
    @(negedge clk);
    ld_vld = 0; prog_start = 0;
  endtask

  task automatic pstart();
    @(negedge clk); prog_start = 1;
    @(negedge clk); prog_start = 0;
  endtask

  task automatic expect3(bit p, bit a, bit s, string req);
    chk(prot_on, p, "prot_on", req);
    chk(wr_allow, a, "wr_allow", req);
    chk(cmd_sup, s, "cmd_sup", req);
  endtask

  task automatic code_unlock(string req);
    load('h5555, 'hAA); chk(cmd_sup, 1, "unlock step1", req);
    load('h2AAA, 'h55); chk(cmd_sup, 1, "unlock step2", req);
    load('h5555, 'hA0); chk(cmd_sup, 1, "unlock step3", req);
    chk(wr_allow, 0, "unlock step3 allow", req);
  endtask

  task automatic code_disable(string req);
    load('h5555, 'hAA); chk(cmd_sup, 1, "dis1", req);
    load('h2AAA, 'h55); chk(cmd_sup, 1, "dis2", req);
    load('h5555, 'h80); chk(cmd_sup, 1, "dis3", req);
    load('h5555, 'hAA); chk(cmd_sup, 1, "dis4", req);
    load('h2AAA, 'h55); chk(cmd_sup, 1, "dis5", req);
    load('h5555, 'h20); chk(cmd_sup, 1, "dis6", req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    cur_req = "R1";
    expect3(0, 0, 0, "R1");

    // R7 plain write while unprotected
    cur_req = "R7";
    load('h0100, 'h12); expect3(0, 1, 0, "R7");

    // R3 code alone does not arm; R5 window closes on prog_start
    cur_req = "R3";
    code_unlock("R3");
    @(negedge clk); chk(prot_on, 0, "code alone", "R3");
    pstart();
    load('h0101, 'h34); expect3(0, 1, 0, "R5 window closed, no arm");

    // R4 unlock + data arms protection; R5 page window
    cur_req = "R4";
    code_unlock("R4");
    load('h0200, 'h33); expect3(1, 1, 0, "R4");
    cur_req = "R5";
    load('h0201, 'h44); expect3(1, 1, 0, "R5");
    load('h0202, 'h45, 1); expect3(1, 1, 0, "R5 load with prog_start");
    // R6 blocked outside window
    cur_req = "R6";
    load('h0203, 'h46); expect3(1, 0, 0, "R6");

    // R9 broken sequence judged as ordinary (blocked) write
    cur_req = "R9";
    load('h5555, 'hAA); chk(cmd_sup, 1, "R9 step1", "R9");
    load('h1234, 'h56); expect3(1, 0, 0, "R9");
    load('h2AAA, 'h55); expect3(1, 0, 0, "R9 no stale step");

    // R10 restart on a repeated first step
    cur_req = "R10";
    load('h5555, 'hAA);
    load('h5555, 'hAA); expect3(1, 0, 1, "R10 restart");
    load('h2AAA, 'h55); chk(cmd_sup, 1, "R10 step2", "R10");
    load('h5555, 'hA0); chk(cmd_sup, 1, "R10 step3", "R10");
    load('h0300, 'h77); expect3(1, 1, 0, "R10 data");
    pstart();

    // R8 disable code
    cur_req = "R8";
    code_disable("R8");
    chk(prot_on, 0, "after disable", "R8");
    chk(wr_allow, 0, "disable data not written", "R8");
    cur_req = "R7";
    load('h0400, 'h88); expect3(0, 1, 0, "R7 after disable");

    // R11 disable while unprotected
    cur_req = "R11";
    code_disable("R11");
    chk(prot_on, 0, "stays off", "R11");

    // R2 mixed random stream against the model
    cur_req = "R2";
    for (int i = 0; i < 600; i++) begin
      int k;
      int a;
      int d;
      k = int'($urandom % 9);
      case (k)
        0: begin a = 'h5555; d = 'hAA; end
        1: begin a = 'h2AAA; d = 'h55; end
        2: begin a = 'h5555; d = 'hA0; end
        3: begin a = 'h5555; d = 'h80; end
        4: begin a = 'h5555; d = 'h20; end
        default: begin a = int'($urandom % 32768); d = int'($urandom % 256); end
      endcase
      if ($urandom % 6 == 0) begin
        pstart();
      end else begin
        load(a, d, ($urandom % 10) == 0);
      end
      if ($urandom % 4 == 0) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule